// File: doc/BRIEF.md
# Floating-Point Operand Unpacker

This block sits between a register-file read port and the arithmetic datapath of a floating-point unit. It accepts a packed operand of up to 128 bits together with a format code, and turns it into one shared internal form: a sign, a signed unbiased exponent, a 128-bit mantissa whose leading one is parked at bit 124, a sticky bit and a class code. Both integer widths and all three floating widths land in that same form, so later stages never need to know what the source format was.

The operand is left-justified on `in_opnd`. The first 32-bit word is `in_opnd[127:96]`, a 64-bit operand uses `in_opnd[127:64]`, and a quad uses all 128 bits. Subnormals and integers go through one leading-zero count and one barrel shift. Signalling NaNs come out already quieted, and their original kind is kept in the class code. A valid/ready handshake runs on both sides. One operand is in flight at a time: one cycle captures and decodes it, the next normalizes it, and the result is then held until it is taken.

Top module: `fp_unpacker`

## Requirements
- R1: `out_sign` always equals `in_opnd[127]` of the accepted operand, for every format, including integers and zeros.
- R2: A floating operand (format 2 single, 3 double, 4 quad) with a zero exponent field and a zero fraction gives class ZERO (code 0), with `out_mant` and `out_exp` both zero.
- R3: A floating operand with a zero exponent field and a nonzero fraction is a subnormal. Its exponent starts at 1 minus the bias (127, 1023 or 16383) and gets no implied one. It is then normalized so that `out_mant[124]` is 1 and bits 127..125 are 0, and the exponent is lowered by the shift. The class is NUM (code 1).
- R4: An exponent field of all ones with a zero fraction gives class INF (code 2), with `out_mant` and `out_exp` zero.
- R5: An exponent field of all ones with a nonzero fraction whose top bit is 1 gives class QNAN (code 3). The aligned fraction is passed through, `out_exp` is 0 and `out_invalid` is 0.
- R6: An exponent field of all ones with a nonzero fraction whose top bit is 0 gives class SNAN (code 4). `out_mant[123]` is set, the rest of the fraction is passed through, and `out_invalid` is 1.
- R7: A normal operand gives class NUM. `out_exp` is the field minus the bias. The fraction's top bit sits at `out_mant[123]` (single fraction in bits 123..101, double in 123..72, quad in 123..12), and the implied one is at bit 124.
- R8: Integer formats are 0 (32-bit, taken from `in_opnd[127:96]`) and 1 (64-bit, taken from `in_opnd[127:64]`), both two's complement. A zero value gives class ZERO. A nonzero value gives class NUM with a magnitude equal to `out_mant * 2^(out_exp-124)` exactly, and with the leading one at bit 124.
- R9: `out_sticky` is 0 on every result.
- R10: Format codes 5, 6 and 7 are unsupported. When one is accepted, `fmt_err` is high for exactly the one cycle after the accepting edge, and no result is produced.
- R11: `in_ready` is high only when nothing is in flight. A result appears on `out_valid` two edges after the accepting edge, and it stays valid and unchanged until the edge at which `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit can accept an operand |
| in_fmt | input | 3 | Format code: 0 int32, 1 int64, 2 single, 3 double, 4 quad |
| in_opnd | input | 128 | Left-justified packed operand |
| out_valid | output | 1 | Unpacked result available |
| out_ready | input | 1 | Consumer takes the result |
| out_sign | output | 1 | Sign |
| out_exp | output | 18 | Signed unbiased exponent |
| out_mant | output | 128 | Mantissa, leading one at bit 124 |
| out_sticky | output | 1 | Sticky bit, always cleared |
| out_class | output | 3 | 0 ZERO, 1 NUM, 2 INF, 3 QNAN, 4 SNAN |
| out_invalid | output | 1 | Invalid-operand flag (signalling NaN seen) |
| fmt_err | output | 1 | Unsupported format code was accepted |

## Verification
An operand is accepted at a rising edge, and `out_valid` and the result fields become visible after the second edge that follows. The bench drives on falling edges and makes two samples per operand. The first falls after the accepting edge, where `out_valid` must still be low. The second falls after the next edge, where every field is compared. `fmt_err` is due after the accepting edge itself, so its check is made one sample earlier, and the same sample confirms that `out_valid` stays low. For back-pressure the bench holds `out_ready` low for several cycles and checks, at every falling edge, that the fields do not change and that `in_ready` stays low.

// File: rtl/fp_unpack_pkg.sv
// Package: shared constants and types for the operand unpacker.
// Assumes a 128-bit internal mantissa with the leading one at bit 124.
package fp_unpack_pkg;

    localparam int MANT_W   = 128;
    localparam int EXP_W    = 18;
    localparam int LEAD_POS = 124;
    localparam int HEAD_W   = MANT_W - 1 - LEAD_POS;   // headroom bits above the leading one
    localparam int LZ_W     = $clog2(MANT_W + 1);

    typedef enum logic [2:0] {
        FMT_I32 = 3'd0,
        FMT_I64 = 3'd1,
        FMT_SGL = 3'd2,
        FMT_DBL = 3'd3,
        FMT_QAD = 3'd4
    } fmt_e;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } cls_e;

    typedef struct packed {
        logic                    sign;
        logic signed [EXP_W-1:0] exp;
        logic [MANT_W-1:0]       mant;
        cls_e                    cls;
        logic                    inv;
    } unpk_t;

endpackage

// File: rtl/fp_unpack_lzc.sv
// Leading-zero counter: counts the zeros above the highest set bit of a
// vector. An all-zero input yields W. Purely combinational.
module fp_unpack_lzc #(
    parameter int W    = 128,
    parameter int CW   = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] lz
);

    // Priority scan: the highest set bit wins because it is visited last.
    always_comb begin
        lz = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) lz = CW'(W - 1 - i);
        end
    end

endmodule

// File: rtl/fp_unpack_decode.sv
// Format decoder: splits a left-justified packed operand into sign, a
// pre-normalization exponent, an aligned mantissa and a class. Assumes the
// first 32-bit word sits in opnd[127:96]. Combinational only.
module fp_unpack_decode
    import fp_unpack_pkg::*;
(
    input  logic [2:0]        fmt,
    input  logic [MANT_W-1:0] opnd,
    output unpk_t             dec,
    output logic              fmt_ok
);

    // Common float classification once fields are aligned under bit 123.
    function automatic unpk_t float_split(
        input logic                    sgn,
        input logic                    e_zero,
        input logic                    e_full,
        input logic signed [EXP_W-1:0] e_norm,
        input logic signed [EXP_W-1:0] e_sub,
        input logic [MANT_W-1:0]       frac_al
    );
        unpk_t r;
        r.sign = sgn;
        r.exp  = '0;
        r.mant = '0;
        r.cls  = CLS_ZERO;
        r.inv  = 1'b0;
        if (e_zero) begin
            if (frac_al != '0) begin
                r.cls  = CLS_NUM;
                r.exp  = e_sub;
                r.mant = frac_al;
            end
        end else if (e_full) begin
            if (frac_al == '0) begin
                r.cls = CLS_INF;
            end else if (frac_al[LEAD_POS-1]) begin
                r.cls  = CLS_QNAN;
                r.mant = frac_al;
            end else begin
                r.cls  = CLS_SNAN;
                r.inv  = 1'b1;
                r.mant = frac_al | (MANT_W'(1) << (LEAD_POS - 1));
            end
        end else begin
            r.cls  = CLS_NUM;
            r.exp  = e_norm;
            r.mant = frac_al | (MANT_W'(1) << LEAD_POS);
        end
        return r;
    endfunction

    // Integer path: sign-magnitude then a fixed exponent of LEAD_POS.
    function automatic unpk_t int_split(input logic sgn, input logic [63:0] val);
        unpk_t r;
        logic [63:0] mag;
        mag    = sgn ? (64'd0 - val) : val;
        r.sign = sgn;
        r.inv  = 1'b0;
        if (val == 64'd0) begin
            r.cls  = CLS_ZERO;
            r.exp  = '0;
            r.mant = '0;
        end else begin
            r.cls  = CLS_NUM;
            r.exp  = EXP_W'(LEAD_POS);
            r.mant = MANT_W'(mag);
        end
        return r;
    endfunction

    logic              sgn;
    logic [7:0]        s_e;
    logic [10:0]       d_e;
    logic [14:0]       q_e;
    logic [MANT_W-1:0] s_fr, d_fr, q_fr;

    // Field extraction for each floating width, fraction top bit at 123.
    always_comb begin
        sgn  = opnd[127];
        s_e  = opnd[126:119];
        d_e  = opnd[126:116];
        q_e  = opnd[126:112];
        s_fr = {{HEAD_W+1{1'b0}}, opnd[118:96], 101'd0};
        d_fr = {{HEAD_W+1{1'b0}}, opnd[115:64], 72'd0};
        q_fr = {{HEAD_W+1{1'b0}}, opnd[111:0], 12'd0};
    end

    // Format select.
    always_comb begin
        fmt_ok = 1'b1;
        case (fmt)
            FMT_I32: dec = int_split(sgn, {{32{opnd[127]}}, opnd[127:96]});
            FMT_I64: dec = int_split(sgn, opnd[127:64]);
            FMT_SGL: dec = float_split(sgn, s_e == '0, s_e == '1,
                                       EXP_W'(s_e) - EXP_W'(127),
                                       EXP_W'(1) - EXP_W'(127), s_fr);
            FMT_DBL: dec = float_split(sgn, d_e == '0, d_e == '1,
                                       EXP_W'(d_e) - EXP_W'(1023),
                                       EXP_W'(1) - EXP_W'(1023), d_fr);
            FMT_QAD: dec = float_split(sgn, q_e == '0, q_e == '1,
                                       EXP_W'(q_e) - EXP_W'(16383),
                                       EXP_W'(1) - EXP_W'(16383), q_fr);
            default: begin
                fmt_ok = 1'b0;
                dec    = '0;
            end
        endcase
    end

endmodule

// File: rtl/fp_unpack_norm.sv
// Normalizer: for class NUM, left-shifts the mantissa so the leading one lands
// on LEAD_POS and lowers the exponent by the same amount. Other classes pass
// through. Assumes a NUM mantissa is nonzero with its leading one at or below
// LEAD_POS.
module fp_unpack_norm
    import fp_unpack_pkg::*;
(
    input  unpk_t pre,
    output unpk_t post
);

    logic [LZ_W-1:0] lz;
    logic [LZ_W-1:0] shamt;

    fp_unpack_lzc #(.W(MANT_W), .CW(LZ_W)) u_lzc (
        .vec (pre.mant),
        .lz  (lz)
    );

    // Shift amount and the shifted result.
    always_comb begin
        shamt = (pre.cls == CLS_NUM) ? (lz - LZ_W'(HEAD_W)) : '0;
        post      = pre;
        post.mant = pre.mant << shamt;
        post.exp  = pre.exp - EXP_W'(shamt);
    end

endmodule

// File: rtl/fp_unpacker.sv
// Operand unpacker top: accepts one packed operand, decodes it into a stage
// register, normalizes on the next cycle, and holds the result until it is
// taken. Assumes one operand in flight; in_ready is high only when idle.
module fp_unpacker
    import fp_unpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_fmt,
    input  logic [MANT_W-1:0] in_opnd,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sign,
    output logic [EXP_W-1:0]  out_exp,
    output logic [MANT_W-1:0] out_mant,
    output logic              out_sticky,
    output logic [2:0]        out_class,
    output logic              out_invalid,
    output logic              fmt_err
);

    typedef enum logic [1:0] {ST_IDLE, ST_NORM, ST_HOLD} st_e;

    st_e   state;
    unpk_t dec, stg, nrm, res;
    logic  fmt_ok, err_q;
    logic  take;

    fp_unpack_decode u_dec (
        .fmt    (in_fmt),
        .opnd   (in_opnd),
        .dec    (dec),
        .fmt_ok (fmt_ok)
    );

    fp_unpack_norm u_norm (
        .pre  (stg),
        .post (nrm)
    );

    // Handshake terms.
    always_comb begin
        in_ready  = (state == ST_IDLE);
        out_valid = (state == ST_HOLD);
        take      = in_valid && in_ready;
    end

    // Sequencer and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            err_q <= 1'b0;
        end else begin
            err_q <= take && !fmt_ok;
            case (state)
                ST_IDLE: if (take && fmt_ok) state <= ST_NORM;
                ST_NORM: state <= ST_HOLD;
                ST_HOLD: if (out_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode stage register.
    always_ff @(posedge clk) begin
        if (!rst_n)                 stg <= '0;
        else if (take && fmt_ok)    stg <= dec;
    end

    // Result register, loaded after normalization.
    always_ff @(posedge clk) begin
        if (!rst_n)                 res <= '0;
        else if (state == ST_NORM)  res <= nrm;
    end

    // Output wiring.
    always_comb begin
        out_sign    = res.sign;
        out_exp     = res.exp;
        out_mant    = res.mant;
        out_class   = res.cls;
        out_invalid = res.inv;
        out_sticky  = 1'b0;
        fmt_err     = err_q;
    end

    // R11: no new operand while a result is pending.
    a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R11: a held result does not change while the consumer stalls.
    a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_mant)
                                       && $stable(out_exp) && $stable(out_class)));

    // R11: nothing is visible on the edge right after acceptance.
    a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !out_valid);

    // R3: a number reaching the normalizer has its leading one at or below LEAD_POS.
    a_r3_norm_input: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORM && stg.cls == CLS_NUM) |->
            (stg.mant != '0 && stg.mant[MANT_W-1:LEAD_POS+1] == '0));

    // R3: a NUM result always has its leading one at LEAD_POS.
    a_r3_lead_one: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == CLS_NUM) |->
            (out_mant[LEAD_POS] && out_mant[MANT_W-1:LEAD_POS+1] == '0));

    // R6: the invalid flag goes with signalling NaNs only.
    a_r6_invalid_snan: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_invalid == (out_class == CLS_SNAN)));

    // R5: every NaN leaves with its quiet bit set.
    a_r5_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_class == CLS_QNAN || out_class == CLS_SNAN)) |->
            out_mant[LEAD_POS-1]);

    // R10: a format error never comes with a result.
    a_r10_err_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |-> !out_valid);

endmodule

// File: tb/sim_fp_unpacker.sv
module sim_fp_unpacker;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [2:0]   in_fmt = 3'd0;
    logic [127:0] in_opnd = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic         out_sign;
    logic [17:0]  out_exp;
    logic [127:0] out_mant;
    logic         out_sticky;
    logic [2:0]   out_class;
    logic         out_invalid;
    logic         fmt_err;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fp_unpacker u0 (.*);

    typedef struct packed {
        logic [2:0]   fmt;
        logic [127:0] opnd;
        logic [2:0]   cls;
        logic         sign;
        logic [17:0]  exp;
        logic [127:0] mant;
        logic         inv;
    } vec_t;

    localparam int NV = 23;
    localparam logic [127:0] ONE124 = 128'h10000000_00000000_00000000_00000000;

    localparam vec_t VECS [NV] = '{
        // single precision: R7 R2 R4 R5 R6 R3
        '{3'd2, {32'h3F800000, 96'd0}, 3'd1, 1'b0, 18'd0, ONE124, 1'b0},
        '{3'd2, {32'hC0200000, 96'd0}, 3'd1, 1'b1, 18'd1, 128'h14000000_00000000_00000000_00000000, 1'b0},
        '{3'd2, {32'h7F800000, 96'd0}, 3'd2, 1'b0, 18'd0, 128'd0, 1'b0},
        '{3'd2, {32'h7FC00000, 96'd0}, 3'd3, 1'b0, 18'd0, 128'h08000000_00000000_00000000_00000000, 1'b0},
        '{3'd2, {32'hFF800001, 96'd0}, 3'd4, 1'b1, 18'd0, 128'h08000020_00000000_00000000_00000000, 1'b1},
        '{3'd2, {32'h80000000, 96'd0}, 3'd0, 1'b1, 18'd0, 128'd0, 1'b0},
        '{3'd2, {32'h00000001, 96'd0}, 3'd1, 1'b0, -18'sd149, ONE124, 1'b0},
        '{3'd2, {32'h00400000, 96'd0}, 3'd1, 1'b0, -18'sd127, ONE124, 1'b0},
        // double precision
        '{3'd3, {64'h3FF00000_00000000, 64'd0}, 3'd1, 1'b0, 18'd0, ONE124, 1'b0},
        '{3'd3, {64'h00080000_00000000, 64'd0}, 3'd1, 1'b0, -18'sd1023, ONE124, 1'b0},
        '{3'd3, {64'h7FF00000_00000001, 64'd0}, 3'd4, 1'b0, 18'd0, 128'h08000000_00000100_00000000_00000000, 1'b1},
        '{3'd3, {64'h40091EB8_51EB851F, 64'd0}, 3'd1, 1'b0, 18'd1, 128'h191EB851_EB851F00_00000000_00000000, 1'b0},
        '{3'd3, {64'hFFF00000_00000000, 64'd0}, 3'd2, 1'b1, 18'd0, 128'd0, 1'b0},
        // quad precision
        '{3'd4, 128'h3FFF0000_00000000_00000000_00000000, 3'd1, 1'b0, 18'd0, ONE124, 1'b0},
        '{3'd4, 128'hC0008000_00000000_00000000_00000000, 3'd1, 1'b1, 18'd1, 128'h18000000_00000000_00000000_00000000, 1'b0},
        '{3'd4, 128'h7FFF8000_00000000_00000000_00000001, 3'd3, 1'b0, 18'd0, 128'h08000000_00000000_00000000_00001000, 1'b0},
        // 32-bit integers: R8
        '{3'd0, {32'h00000001, 96'd0}, 3'd1, 1'b0, 18'd0, ONE124, 1'b0},
        '{3'd0, {32'hFFFFFFFF, 96'd0}, 3'd1, 1'b1, 18'd0, ONE124, 1'b0},
        '{3'd0, {32'h80000000, 96'd0}, 3'd1, 1'b1, 18'd31, ONE124, 1'b0},
        '{3'd0, {32'h00000064, 96'hFFFF}, 3'd1, 1'b0, 18'd6, 128'h19000000_00000000_00000000_00000000, 1'b0},
        // 64-bit integers: R8
        '{3'd1, {64'hFFFFFFFF_FFFFFF00, 64'd0}, 3'd1, 1'b1, 18'd8, ONE124, 1'b0},
        '{3'd1, {64'h7FFFFFFF_FFFFFFFF, 64'd0}, 3'd1, 1'b0, 18'd62, 128'h1FFFFFFF_FFFFFFFF_C0000000_00000000, 1'b0},
        '{3'd1, {64'd0, 64'h1234}, 3'd0, 1'b0, 18'd0, 128'd0, 1'b0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp_v);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp_v);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Drive one operand and compare its result two edges after acceptance.
    task automatic run_vec(input vec_t v, input int idx);
        @(negedge clk);
        check(in_ready == 1'b1, "R11", $sformatf("ready before vec %0d", idx), 128'(in_ready), 128'd1);
        in_valid = 1'b1;
        in_fmt   = v.fmt;
        in_opnd  = v.opnd;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R11", $sformatf("early valid vec %0d", idx), 128'(out_valid), 128'd0);
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b1, "R11", $sformatf("valid vec %0d", idx), 128'(out_valid), 128'd1);
        check(out_class == v.cls, "R2-class", $sformatf("class vec %0d (R2 R4 R5 R6 R7 R8)", idx), 128'(out_class), 128'(v.cls));
        check(out_sign == v.sign, "R1", $sformatf("sign vec %0d", idx), 128'(out_sign), 128'(v.sign));
        check(out_exp == v.exp, "R3/R7/R8", $sformatf("exp vec %0d", idx), 128'(out_exp), 128'(v.exp));
        check(out_mant == v.mant, "R3/R7/R8", $sformatf("mant vec %0d", idx), out_mant, v.mant);
        check(out_invalid == v.inv, "R6", $sformatf("invalid vec %0d", idx), 128'(out_invalid), 128'(v.inv));
        check(out_sticky == 1'b0, "R9", $sformatf("sticky vec %0d", idx), 128'(out_sticky), 128'd0);
        @(posedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // Reset state.
        check(out_valid == 1'b0, "R11", "reset out_valid", 128'(out_valid), 128'd0);
        check(in_ready == 1'b1, "R11", "reset in_ready", 128'(in_ready), 128'd1);
        check(fmt_err == 1'b0, "R10", "reset fmt_err", 128'(fmt_err), 128'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R10: unsupported format codes.
        for (int f = 5; f < 8; f++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_fmt   = 3'(f);
            in_opnd  = 128'h3F800000_00000000_00000000_00000000;
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            check(fmt_err == 1'b1, "R10", $sformatf("fmt_err code %0d", f), 128'(fmt_err), 128'd1);
            check(out_valid == 1'b0, "R10", $sformatf("no result code %0d", f), 128'(out_valid), 128'd0);
            @(posedge clk);
            @(negedge clk);
            check(fmt_err == 1'b0, "R10", $sformatf("fmt_err one cycle code %0d", f), 128'(fmt_err), 128'd0);
            check(out_valid == 1'b0, "R10", $sformatf("still no result code %0d", f), 128'(out_valid), 128'd0);
            check(in_ready == 1'b1, "R10", $sformatf("ready after code %0d", f), 128'(in_ready), 128'd1);
        end

        // R11: back-pressure holds the result and blocks new input.
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_fmt    = 3'd2;
        in_opnd   = {32'hC0200000, 96'd0};
        @(posedge clk);
        @(negedge clk);
        in_opnd = {32'h3F800000, 96'd0};   // offered while busy: must be ignored
        @(posedge clk);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(out_valid == 1'b1, "R11", $sformatf("hold valid %0d", k), 128'(out_valid), 128'd1);
            check(in_ready == 1'b0, "R11", $sformatf("hold ready low %0d", k), 128'(in_ready), 128'd0);
            check(out_mant == 128'h14000000_00000000_00000000_00000000, "R11",
                  $sformatf("hold mant %0d", k), out_mant, 128'h14000000_00000000_00000000_00000000);
            check(out_exp == 18'd1 && out_sign == 1'b1, "R11", $sformatf("hold exp/sign %0d", k),
                  128'({out_sign, out_exp}), 128'({1'b1, 18'd1}));
        end
        in_valid  = 1'b0;
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R11", "released after take", 128'(out_valid), 128'd0);
        check(in_ready == 1'b1, "R11", "ready after take", 128'(in_ready), 128'd1);
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R11", "busy offer not accepted", 128'(out_valid), 128'd0);

        finish_up();
    end

endmodule